// File: doc/BRIEF.md
# Stop-State Entry and Wake Controller

This controller puts a processor subsystem into a fully halted stop state and brings it back out. A one-cycle strobe from the core's STOP bit write drives a halt output that gates every clocked circuit downstream: the core, timers, serial ports and other peripherals. The controller itself runs on the free-running clock. It also holds the clock-control register contents, so the operating frequency in use before the halt is still in place after an interrupt wake.

Two kinds of event end the halt, and they end it differently. An external reset event or a power-on/brownout event raises a reset request, and the subsystem goes through a normal reset sequence. The clock-control register returns to its reset value. An interrupt request can wake the block only if it was armed when the halt began. A request is armed when its local enable, its module enable and the global enable were all set in the cycle the STOP strobe was taken. The supply-monitor request also needs its stop-wake enable set. An interrupt wake raises a one-cycle resume request. That request carries the interrupt vector, the mask of waking sources and the return address captured at entry, which is the instruction after the one that set STOP. The clock settings are kept.

Top module: `stop_wake_ctrl`

## Requirements
- R1: When `stop_set` is high, `halt` is low and no reset event is present, `halt` is high after the next rising edge. A `stop_set` that arrives while `halt` is already high has no effect, and `resume_ret` keeps the address captured at entry.
- R2: While `halt` is low, `ckc_wr` loads `ckc_wdata` into `ckc_q` at the next edge. While `halt` is high, `ckc_wr` is ignored and `ckc_q` holds its value.
- R3: A source i is armed when bit i of `irq_loc_en`, bit i of `irq_mod_en` and `irq_glb_en` were all 1 in the entry cycle. Changes to these enables while halted have no effect. Unarmed requests do not end the halt.
- R4: Source NSRC-1 (the top bit) is the supply-monitor request. It is armed only if `svm_stop_en` was also 1 in the entry cycle.
- R5: While halted, an armed request with no reset event present clears `halt` at the next edge. In that same cycle `resume_req` is high for one cycle, `resume_src` holds the armed request mask, `resume_vec` holds `ivec_in` from the wake cycle, `resume_ret` holds `stop_pc` from the entry cycle, and `ckc_q` is unchanged.
- R6: A reset event (`ext_rst_evt` or `pwr_rst_evt`) makes `rst_req` high in the following cycle, clears `halt`, and sets `ckc_q` to CKC_RST.
- R7: When a reset event and an armed interrupt request occur in the same halted cycle, only `rst_req` rises. `resume_req` stays low and `resume_src` is 0.
- R8: Interrupt requests while `halt` is low never raise `resume_req`.
- R9: After `rst_n` is asserted: `halt`, `rst_req` and `resume_req` are 0, `resume_src` is 0, and `ckc_q` equals CKC_RST (default 8'h5A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock (never gated) |
| rst_n | input | 1 | Active-low asynchronous block reset |
| stop_set | input | 1 | One-cycle strobe: STOP bit written to 1 |
| stop_pc | input | AW | Address of the instruction after the STOP write |
| ext_rst_evt | input | 1 | External reset event |
| pwr_rst_evt | input | 1 | Power-on / brownout reset event |
| irq_src | input | NSRC | Interrupt requests; top bit is the supply monitor |
| irq_loc_en | input | NSRC | Local enables per source |
| irq_mod_en | input | NSRC | Module enables per source |
| irq_glb_en | input | 1 | Global interrupt enable |
| svm_stop_en | input | 1 | Allows the supply-monitor request to wake from stop |
| ivec_in | input | AW | Current interrupt vector register value |
| ckc_wr | input | 1 | Clock-control register write strobe |
| ckc_wdata | input | CKW | Clock-control write data |
| halt | output | 1 | 1 = downstream clocks gated off |
| ckc_q | output | CKW | Clock-control register contents |
| rst_req | output | 1 | Request for a full reset sequence |
| resume_req | output | 1 | One-cycle request to resume through the interrupt vector |
| resume_vec | output | AW | Vector to take on resume |
| resume_ret | output | AW | Return address captured at stop entry |
| resume_src | output | NSRC | Armed requests that caused the wake |

## Verification
The key overlap is a reset event and an armed interrupt request in the same halted cycle. The reset must win, and it must also override a clock-control write and a STOP strobe presented in that cycle. A directed case enters stop, then drives `ext_rst_evt` and an armed request together. The bench then checks that `rst_req` alone rises, `resume_src` stays 0 and `ckc_q` returns to its reset value. The constrained-random phase raises reset events and requests independently, so they collide many times in and out of the halt. A bench reference model rebuilds the outputs each cycle and flags any disagreement.

// File: rtl/swk_pkg.sv
package swk_pkg;
  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_IRQ  = 2'd1,
    WK_RST  = 2'd2
  } wake_kind_e;
endpackage

// File: rtl/swk_arm.sv
module swk_arm #(
  parameter int NSRC    = 4,
  parameter int SVM_IDX = NSRC - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic [NSRC-1:0] loc_en,
  input  logic [NSRC-1:0] mod_en,
  input  logic            glb_en,
  input  logic            svm_en,
  output logic [NSRC-1:0] arm_q
);
  function automatic logic [NSRC-1:0] arm_calc(
    input logic [NSRC-1:0] l, input logic [NSRC-1:0] m,
    input logic g, input logic s);
    logic [NSRC-1:0] r;
    r = l & m & {NSRC{g}};
    r[SVM_IDX] = r[SVM_IDX] & s;
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arm_q <= '0;
    else if (capture) arm_q <= arm_calc(loc_en, mod_en, glb_en, svm_en);
  end

  AST_SVM_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !svm_en) |=> !arm_q[SVM_IDX]); // R4
  AST_ARM_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(arm_q)); // R3
endmodule

// File: rtl/swk_wake_det.sv
module swk_wake_det
  import swk_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            halted,
  input  logic [NSRC-1:0] arm,
  input  logic [NSRC-1:0] irq_src,
  input  logic            ext_rst,
  input  logic            pwr_rst,
  output logic [NSRC-1:0] hit,
  output wake_kind_e      kind
);
  function automatic wake_kind_e pick(input logic r, input logic h, input logic any_hit);
    if (r)                 return WK_RST;
    else if (h && any_hit) return WK_IRQ;
    else                   return WK_NONE;
  endfunction

  always_comb begin
    hit  = halted ? (irq_src & arm) : '0;
    kind = pick(ext_rst | pwr_rst, halted, |hit);
  end
endmodule

// File: rtl/swk_ckc_hold.sv
module swk_ckc_hold #(
  parameter int             CKW     = 8,
  parameter logic [CKW-1:0] CKC_RST = 8'h5A
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           halted,
  input  logic           rst_evt,
  input  logic           wr,
  input  logic [CKW-1:0] wdata,
  output logic [CKW-1:0] ckc_q
);
  logic wr_ok;
  assign wr_ok = wr && !halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ckc_q <= CKC_RST;
    else if (rst_evt) ckc_q <= CKC_RST;
    else if (wr_ok)   ckc_q <= wdata;
  end

  AST_CKC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !rst_evt) |=> $stable(ckc_q)); // R2
  AST_CKC_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    rst_evt |=> (ckc_q == CKC_RST)); // R6
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
  import swk_pkg::*;
#(
  parameter int             NSRC    = 4,
  parameter int             AW      = 16,
  parameter int             CKW     = 8,
  parameter logic [CKW-1:0] CKC_RST = 8'h5A
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            stop_set,
  input  logic [AW-1:0]   stop_pc,
  input  logic            ext_rst_evt,
  input  logic            pwr_rst_evt,
  input  logic [NSRC-1:0] irq_src,
  input  logic [NSRC-1:0] irq_loc_en,
  input  logic [NSRC-1:0] irq_mod_en,
  input  logic            irq_glb_en,
  input  logic            svm_stop_en,
  input  logic [AW-1:0]   ivec_in,
  input  logic            ckc_wr,
  input  logic [CKW-1:0]  ckc_wdata,
  output logic            halt,
  output logic [CKW-1:0]  ckc_q,
  output logic            rst_req,
  output logic            resume_req,
  output logic [AW-1:0]   resume_vec,
  output logic [AW-1:0]   resume_ret,
  output logic [NSRC-1:0] resume_src
);
  localparam int SVM_IDX = NSRC - 1;

  logic            halt_q;
  logic            rst_evt;
  logic            enter_stop;
  logic [NSRC-1:0] arm_q;
  logic [NSRC-1:0] hit;
  wake_kind_e      kind;

  assign rst_evt    = ext_rst_evt | pwr_rst_evt;
  assign enter_stop = stop_set && !halt_q && !rst_evt;
  assign halt       = halt_q;

  swk_arm #(.NSRC(NSRC), .SVM_IDX(SVM_IDX)) u_arm (
    .clk(clk), .rst_n(rst_n), .capture(enter_stop),
    .loc_en(irq_loc_en), .mod_en(irq_mod_en), .glb_en(irq_glb_en),
    .svm_en(svm_stop_en), .arm_q(arm_q));

  swk_wake_det #(.NSRC(NSRC)) u_det (
    .halted(halt_q), .arm(arm_q), .irq_src(irq_src),
    .ext_rst(ext_rst_evt), .pwr_rst(pwr_rst_evt),
    .hit(hit), .kind(kind));

  swk_ckc_hold #(.CKW(CKW), .CKC_RST(CKC_RST)) u_ckc (
    .clk(clk), .rst_n(rst_n), .halted(halt_q), .rst_evt(rst_evt),
    .wr(ckc_wr), .wdata(ckc_wdata), .ckc_q(ckc_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q     <= 1'b0;
      rst_req    <= 1'b0;
      resume_req <= 1'b0;
      resume_src <= '0;
      resume_vec <= '0;
      resume_ret <= '0;
    end else begin
      rst_req    <= (kind == WK_RST);
      resume_req <= (kind == WK_IRQ);
      resume_src <= (kind == WK_IRQ) ? hit : '0;
      if (kind == WK_IRQ) resume_vec <= ivec_in;
      if (enter_stop)     resume_ret <= stop_pc;
      case (kind)
        WK_RST:  halt_q <= 1'b0;
        WK_IRQ:  halt_q <= 1'b0;
        default: if (enter_stop) halt_q <= 1'b1;
      endcase
    end
  end

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_set && !halt && !rst_evt) |=> halt); // R1
  AST_RET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> $stable(resume_ret)); // R1
  AST_RESUME_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    resume_req |-> (!halt && resume_src != '0)); // R5
  AST_RST_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (!resume_req && resume_src == '0 && !halt)); // R7
  AST_NO_RUN_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |=> !resume_req); // R8
endmodule

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
  localparam int          NSRC = 4;
  localparam int          AW   = 16;
  localparam int          CKW  = 8;
  localparam logic [7:0]  CRST = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stop_set = 0, ext_rst_evt = 0, pwr_rst_evt = 0, irq_glb_en = 0, svm_stop_en = 0, ckc_wr = 0;
  logic [AW-1:0] stop_pc = '0, ivec_in = '0;
  logic [NSRC-1:0] irq_src = '0, irq_loc_en = '0, irq_mod_en = '0;
  logic [CKW-1:0] ckc_wdata = '0;
  logic halt, rst_req, resume_req;
  logic [CKW-1:0] ckc_q;
  logic [AW-1:0] resume_vec, resume_ret;
  logic [NSRC-1:0] resume_src;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stop_wake_ctrl #(.NSRC(NSRC), .AW(AW), .CKW(CKW), .CKC_RST(CRST)) i_stop_wake_ctrl (
    .clk(clk), .rst_n(rst_n), .stop_set(stop_set), .stop_pc(stop_pc),
    .ext_rst_evt(ext_rst_evt), .pwr_rst_evt(pwr_rst_evt), .irq_src(irq_src),
    .irq_loc_en(irq_loc_en), .irq_mod_en(irq_mod_en), .irq_glb_en(irq_glb_en),
    .svm_stop_en(svm_stop_en), .ivec_in(ivec_in), .ckc_wr(ckc_wr), .ckc_wdata(ckc_wdata),
    .halt(halt), .ckc_q(ckc_q), .rst_req(rst_req), .resume_req(resume_req),
    .resume_vec(resume_vec), .resume_ret(resume_ret), .resume_src(resume_src));

  // reference model, built from the requirements
  logic m_halt, m_rreq, m_qreq;
  logic [NSRC-1:0] m_arm, m_src;
  logic [AW-1:0] m_vec, m_ret;
  logic [CKW-1:0] m_ckc;

  function automatic logic [NSRC-1:0] armed_of(input logic [NSRC-1:0] l, m,
                                                input logic g, s);
    logic [NSRC-1:0] r;
    for (int i = 0; i < NSRC; i++)
      r[i] = g && l[i] && m[i] && ((i != NSRC-1) || s);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_halt <= 0; m_rreq <= 0; m_qreq <= 0; m_arm <= '0; m_src <= '0;
      m_vec <= '0; m_ret <= '0; m_ckc <= CRST;
    end else begin
      logic r;
      logic [NSRC-1:0] h;
      r = ext_rst_evt || pwr_rst_evt;
      h = m_halt ? (irq_src & m_arm) : '0;
      m_rreq <= r;
      m_qreq <= !r && (h != 0);
      m_src  <= (!r && (h != 0)) ? h : '0;
      if (!r && (h != 0)) m_vec <= ivec_in;
      if (r) m_ckc <= CRST;
      else if (ckc_wr && !m_halt) m_ckc <= ckc_wdata;
      if (r || (h != 0)) m_halt <= 0;
      else if (!m_halt && stop_set) begin
        m_halt <= 1;
        m_arm  <= armed_of(irq_loc_en, irq_mod_en, irq_glb_en, svm_stop_en);
        m_ret  <= stop_pc;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cmp_model();
    chk("R1 halt", {31'd0, halt}, {31'd0, m_halt});
    chk("R2 ckc_q", {24'd0, ckc_q}, {24'd0, m_ckc});
    chk("R6 rst_req", {31'd0, rst_req}, {31'd0, m_rreq});
    chk("R5 resume_req", {31'd0, resume_req}, {31'd0, m_qreq});
    chk("R3 resume_src", {28'd0, resume_src}, {28'd0, m_src});
    chk("R5 resume_vec", {16'd0, resume_vec}, {16'd0, m_vec});
    chk("R5 resume_ret", {16'd0, resume_ret}, {16'd0, m_ret});
  endtask

  task automatic cyc();
    @(negedge clk);
    cmp_model();
  endtask

  task automatic idle();
    stop_set = 0; ext_rst_evt = 0; pwr_rst_evt = 0; ckc_wr = 0; irq_src = '0;
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // R9 reset state
    chk("R9 halt", {31'd0, halt}, 0);
    chk("R9 ckc", {24'd0, ckc_q}, {24'd0, CRST});
    chk("R9 reqs", {30'd0, rst_req, resume_req}, 0);
    chk("R9 src", {28'd0, resume_src}, 0);
    // R2 write while running
    ckc_wr = 1; ckc_wdata = 8'h33; cyc(); idle();
    chk("R2 load", {24'd0, ckc_q}, 32'h33);
    // R1 entry, svm not allowed
    irq_loc_en = '1; irq_mod_en = '1; irq_glb_en = 1; svm_stop_en = 0;
    stop_set = 1; stop_pc = 16'h1234; cyc(); idle();
    chk("R1 enter", {31'd0, halt}, 1);
    // R2 write ignored, R1 second stop ignored
    ckc_wr = 1; ckc_wdata = 8'h77; stop_set = 1; stop_pc = 16'h9999; cyc(); idle();
    chk("R2 hold", {24'd0, ckc_q}, 32'h33);
    chk("R1 ret kept", {16'd0, resume_ret}, 32'h1234);
    // R4 svm request not armed
    irq_src = 4'b1000; cyc(); idle();
    chk("R4 svm blocked", {31'd0, halt}, 1);
    // R3 enables dropped during stop do not matter; R5 wake
    irq_loc_en = '0; irq_glb_en = 0; ivec_in = 16'h0AB0;
    irq_src = 4'b0010; cyc(); idle();
    chk("R5 halt off", {31'd0, halt}, 0);
    chk("R5 resume_req", {31'd0, resume_req}, 1);
    chk("R3 src", {28'd0, resume_src}, 32'h2);
    chk("R5 vec", {16'd0, resume_vec}, 32'h0AB0);
    chk("R5 ret", {16'd0, resume_ret}, 32'h1234);
    chk("R5 ckc kept", {24'd0, ckc_q}, 32'h33);
    // R8 request while running
    irq_src = 4'b0011; cyc(); idle();
    chk("R8 no resume", {31'd0, resume_req}, 0);
    // R7 reset and irq in same halted cycle
    irq_loc_en = '1; irq_glb_en = 1; stop_set = 1; stop_pc = 16'h2000; cyc(); idle();
    ext_rst_evt = 1; irq_src = 4'b0001; ckc_wr = 1; ckc_wdata = 8'hEE; cyc(); idle();
    chk("R7 rst_req", {31'd0, rst_req}, 1);
    chk("R7 no resume", {31'd0, resume_req}, 0);
    chk("R7 src", {28'd0, resume_src}, 0);
    chk("R6 halt off", {31'd0, halt}, 0);
    chk("R6 ckc reset", {24'd0, ckc_q}, {24'd0, CRST});
    // R4 svm allowed
    svm_stop_en = 1; stop_set = 1; cyc(); idle();
    irq_src = 4'b1000; cyc(); idle();
    chk("R4 svm wake", {28'd0, resume_src}, 32'h8);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      stop_set    = ($urandom_range(0, 3) == 0);
      stop_pc     = 16'($urandom);
      ext_rst_evt = ($urandom_range(0, 59) == 0);
      pwr_rst_evt = ($urandom_range(0, 59) == 0);
      for (int b = 0; b < NSRC; b++) irq_src[b] = ($urandom_range(0, 9) == 0);
      irq_loc_en  = 4'($urandom) | 4'($urandom);
      irq_mod_en  = 4'($urandom) | 4'($urandom);
      irq_glb_en  = ($urandom_range(0, 4) != 0);
      svm_stop_en = $urandom_range(0, 1);
      ivec_in     = 16'($urandom);
      ckc_wr      = ($urandom_range(0, 2) == 0);
      ckc_wdata   = 8'($urandom);
      cyc();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule